// File: doc/BRIEF.md
# Sector Buffer Transfer Engine

This block empties a range of the disc controller's sector buffer toward one of several consumers. Software loads a byte count, a buffer start address and a destination word address, picks a 3-bit transfer mode, and strobes a trigger. In the two host modes the block presents 16-bit words to a CPU read port. Each accepted read pulls two buffer bytes and steps the counters. In the three DMA modes it streams the words itself, one write per accepted clock, toward an audio sample memory, the program memory or the shared word memory. It scales the destination address differently for each of those targets.

A transfer finishes when the byte count runs out. The block then drops its busy and host-ready flags, raises its end flag, and, when enabled, latches a pending end interrupt and pulses a level-5 interrupt request. Clearing the transfer enable while busy stops the transfer at once. The memory arbitration and the buffer contents live outside this block.

Top module: `cdxfer_engine`

## Requirements
- R1: After reset, busy_o, host_rdy_o, done_o, end_pend_o, irq_o, dst_we_o and hrd_data_o are 0, and the three counters read 0.
- R2: A trigger is accepted only while xfer_en_i is 1 and the block is idle. Acceptance sets busy_o and clears done_o in the next cycle.
- R3: Mode 2 (main-CPU host) and mode 3 (sub-CPU host) set host_rdy_o on acceptance. Modes 0, 1 and 6 are invalid: busy_o sets, but host_rdy_o stays 0 and no destination write is issued.
- R4: A host read whose reader does not match the latched mode, or one made while idle, returns 0 and leaves the byte count and data address unchanged. Sub CPU is hrd_sub_i=1 and pairs with mode 3; main CPU pairs with mode 2.
- R5: An accepted host read returns buffer[addr] in bits 15:8 and buffer[addr+1] in bits 7:0 in the cycle after the strobe. It lowers the byte count by 2 and raises the data address by 2.
- R6: When a read or DMA word would take the byte count to zero or below, the count becomes 0, busy_o and host_rdy_o clear, and done_o sets.
- R7: At the end of a transfer with end_irq_en_i set, end_pend_o sets and stays set until ack_i. irq_o pulses for exactly one cycle if irq5_en_i is also set.
- R8: A DMA transfer writes (byte count + 1)/2 words. A word completes only in a cycle where dst_we_o and dst_rdy_i are both 1. The data address advances by 2 per word, modulo 65536.
- R9: The destination byte offset starts at a value set by the mode, and each word adds 2 to it:
  - Mode 4 (dst_sel_o=1): (dma & 0x3FF) << 2.
  - Mode 5 (dst_sel_o=2): dma << 3.
  - Mode 7 (dst_sel_o=3): (dma & 0x7FFF) << 3 when wm_1m_i=0. When wm_1m_i=1 it is (dma & 0x3FFF) << 3, with dst_bank_o equal to the inverse of wm_bank_i.
- R10: After a DMA of W words, the destination word address grows by (2W)>>2 for mode 4 and by (2W)>>3 for modes 5 and 7.
- R11: Clearing xfer_en_i while busy zeroes the byte count and clears busy_o and host_rdy_o. It does not set done_o and raises no interrupt.
- R12: A trigger while busy is ignored, and the latched mode is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_en_i | input | 1 | Transfer enable; low aborts a running transfer |
| end_irq_en_i | input | 1 | Enables the end-of-transfer pending flag |
| irq5_en_i | input | 1 | Enables the level-5 interrupt pulse |
| ack_i | input | 1 | Clears the pending end flag |
| trig_i | input | 1 | Start strobe |
| mode_i | input | 3 | Transfer mode |
| cnt_load_i | input | 1 | Load byte count |
| cnt_val_i | input | CNT_W | Byte count value |
| addr_load_i | input | 1 | Load buffer data address |
| addr_val_i | input | ADDR_W | Data address value |
| dma_load_i | input | 1 | Load destination word address |
| dma_val_i | input | DMA_W | Destination word address value |
| wm_1m_i | input | 1 | Word memory split into two banks |
| wm_bank_i | input | 1 | Bank select bit for split word memory |
| hrd_i | input | 1 | Host read strobe |
| hrd_sub_i | input | 1 | Reader identity: 1 sub CPU, 0 main CPU |
| hrd_data_o | output | 16 | Host read data |
| buf_addr_o | output | ADDR_W | Buffer byte address |
| buf_hi_i | input | 8 | Buffer byte at buf_addr_o |
| buf_lo_i | input | 8 | Buffer byte at buf_addr_o+1 |
| dst_we_o | output | 1 | DMA word write request |
| dst_sel_o | output | 2 | Destination: 1 audio, 2 program, 3 word memory |
| dst_off_o | output | OFF_W | Destination byte offset |
| dst_bank_o | output | 1 | Word memory bank |
| dst_data_o | output | 16 | DMA write data |
| dst_rdy_i | input | 1 | Destination accepts the write |
| busy_o | output | 1 | Transfer in progress |
| host_rdy_o | output | 1 | Data ready at the host port |
| done_o | output | 1 | Transfer end flag |
| end_pend_o | output | 1 | Pending end interrupt |
| irq_o | output | 1 | Level-5 interrupt pulse |
| byte_cnt_o | output | CNT_W | Byte count |
| data_addr_o | output | ADDR_W | Buffer data address |
| dma_addr_o | output | DMA_W | Destination word address |

## Verification
Several behaviours hold on every cycle and are checked by the embedded properties:
- the end flag and busy never overlap;
- host-ready implies busy;
- the count is zero whenever busy falls;
- a stalled write holds its offset and source address;
- a rejected read yields zero;
- the interrupt is a single-cycle pulse that implies the pending flag.

Only the bench scenarios can show the arithmetic:
- the per-destination offset scaling and bank choice;
- the word count drawn from odd and even byte counts;
- the data address wrapping past 65535;
- the destination address advance;
- the abort and ignored-trigger cases, observed at the ports.

// File: rtl/cdxfer_pkg.sv
package cdxfer_pkg;

   typedef enum logic [1:0] {
      DST_NONE = 2'd0,
      DST_PCM  = 2'd1,
      DST_PRG  = 2'd2,
      DST_WORD = 2'd3
   } dst_e;

   typedef enum logic [1:0] {
      K_INVALID   = 2'd0,
      K_HOST_MAIN = 2'd1,
      K_HOST_SUB  = 2'd2,
      K_DMA       = 2'd3
   } kind_e;

   function automatic kind_e mode_kind(input logic [2:0] m);
      case (m)
         3'd2:               return K_HOST_MAIN;
         3'd3:               return K_HOST_SUB;
         3'd4, 3'd5, 3'd7:   return K_DMA;
         default:            return K_INVALID;
      endcase
   endfunction

   function automatic dst_e mode_dst(input logic [2:0] m);
      case (m)
         3'd4:    return DST_PCM;
         3'd5:    return DST_PRG;
         3'd7:    return DST_WORD;
         default: return DST_NONE;
      endcase
   endfunction

endpackage

// File: rtl/cdxfer_dst_map.sv
module cdxfer_dst_map
   import cdxfer_pkg::*;
#(
   parameter int DMA_W      = 16,
   parameter int OFF_W      = 19,
   parameter int PCM_MASK_W = 10,
   parameter int W2M_MASK_W = 15,
   parameter int W1M_MASK_W = 14,
   parameter int PCM_SHIFT  = 2,
   parameter int BIG_SHIFT  = 3,
   parameter bit HAS_1M     = 1'b1
)
(
   input  logic [2:0]       mode_i,
   input  logic [DMA_W-1:0] dma_i,
   input  logic             wm_1m_i,
   input  logic             wm_bank_i,
   output dst_e             dst_o,
   output logic [OFF_W-1:0] base_o,
   output logic             bank_o
);

   localparam int PRG_TOP = DMA_W + BIG_SHIFT;

   generate
      if (OFF_W < PRG_TOP) begin : g_off_w_bad
         $error("cdxfer_dst_map: OFF_W too narrow for program offsets");
      end
      if (PCM_MASK_W > DMA_W || W2M_MASK_W > DMA_W || W1M_MASK_W > DMA_W) begin : g_mask_bad
         $error("cdxfer_dst_map: mask wider than DMA address");
      end
   endgenerate

   logic [OFF_W-1:0] pcm_off;
   logic [OFF_W-1:0] prg_off;
   logic [OFF_W-1:0] w2m_off;
   logic [OFF_W-1:0] w1m_off;
   logic             split_sel;

   assign pcm_off = OFF_W'(dma_i[PCM_MASK_W-1:0]) << PCM_SHIFT;
   assign prg_off = OFF_W'(dma_i)                 << BIG_SHIFT;
   assign w2m_off = OFF_W'(dma_i[W2M_MASK_W-1:0]) << BIG_SHIFT;
   assign w1m_off = OFF_W'(dma_i[W1M_MASK_W-1:0]) << BIG_SHIFT;

   assign dst_o = mode_dst(mode_i);

   generate
      if (HAS_1M) begin : g_banked
         assign split_sel = wm_1m_i;
         assign bank_o    = wm_1m_i & (dst_o == DST_WORD) & ~wm_bank_i;
      end else begin : g_flat
         assign split_sel = 1'b0;
         assign bank_o    = 1'b0;
      end
   endgenerate

   always_comb begin
      case (dst_o)
         DST_PCM:  base_o = pcm_off;
         DST_PRG:  base_o = prg_off;
         DST_WORD: base_o = split_sel ? w1m_off : w2m_off;
         default:  base_o = '0;
      endcase
   end

endmodule

// File: rtl/cdxfer_irq.sv
module cdxfer_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic end_evt_i,
   input  logic end_irq_en_i,
   input  logic irq5_en_i,
   input  logic ack_i,
   output logic end_pend_o,
   output logic irq_o
);

   logic pend_q;
   logic irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         if (end_evt_i && end_irq_en_i)
            pend_q <= 1'b1;
         else if (ack_i)
            pend_q <= 1'b0;
         irq_q <= end_evt_i && end_irq_en_i && irq5_en_i;
      end
   end

   assign end_pend_o = pend_q;
   assign irq_o      = irq_q;

   // R7
   irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |=> !irq_q);

   // R7
   irq_implies_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> pend_q);

endmodule

// File: rtl/cdxfer_seq.sv
module cdxfer_seq
   import cdxfer_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int ADDR_W    = 16,
   parameter int DMA_W     = 16,
   parameter int OFF_W     = 19,
   parameter int PCM_SHIFT = 2,
   parameter int BIG_SHIFT = 3
)
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_en_i,
   input  logic              trig_i,
   input  logic [2:0]        mode_i,
   input  logic              cnt_load_i,
   input  logic [CNT_W-1:0]  cnt_val_i,
   input  logic              addr_load_i,
   input  logic [ADDR_W-1:0] addr_val_i,
   input  logic              dma_load_i,
   input  logic [DMA_W-1:0]  dma_val_i,
   input  logic              hrd_i,
   input  logic              hrd_sub_i,
   input  logic [7:0]        buf_hi_i,
   input  logic [7:0]        buf_lo_i,
   input  logic              dst_rdy_i,
   input  dst_e              dst_i,
   input  logic [OFF_W-1:0]  base_i,
   input  logic              bank_i,
   output logic [15:0]       hrd_data_o,
   output logic              dst_we_o,
   output dst_e              dst_sel_o,
   output logic [OFF_W-1:0]  dst_off_o,
   output logic              dst_bank_o,
   output logic              busy_o,
   output logic              host_rdy_o,
   output logic              done_o,
   output logic              end_evt_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DMA_W-1:0]  dma_o
);

   localparam logic [CNT_W-1:0]  CNT_STEP  = CNT_W'(2);
   localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(2);
   localparam logic [OFF_W-1:0]  OFF_STEP  = OFF_W'(2);

   logic              busy_q, rdy_q, done_q;
   kind_e             kind_q;
   dst_e              dst_q;
   logic              bank_q;
   logic [CNT_W-1:0]  cnt_q, words_q, tot_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DMA_W-1:0]  dma_q;
   logic [OFF_W-1:0]  off_q;
   logic [15:0]       hdata_q;

   logic             run, trig_ok, rd_ok, dma_act, wr_fire;
   logic             dma_last, rd_last, fin, abort;
   logic [CNT_W-1:0] words_new;
   logic [CNT_W:0]   bytes_tot;
   logic [DMA_W-1:0] dma_adv;
   kind_e            kind_now;

   assign run      = busy_q && xfer_en_i;
   assign kind_now = mode_kind(mode_i);
   assign trig_ok  = trig_i && xfer_en_i && !busy_q;
   assign rd_ok    = hrd_i && run &&
                     ((kind_q == K_HOST_MAIN && !hrd_sub_i) ||
                      (kind_q == K_HOST_SUB  &&  hrd_sub_i));
   assign dma_act  = run && (kind_q == K_DMA);
   assign dst_we_o = dma_act && (words_q != '0);
   assign wr_fire  = dst_we_o && dst_rdy_i;
   assign dma_last = dma_act && ((words_q == '0) ||
                                 (words_q == CNT_W'(1) && dst_rdy_i));
   assign rd_last  = rd_ok && (cnt_q <= CNT_STEP);
   assign fin      = dma_last || rd_last;
   assign abort    = busy_q && !xfer_en_i;

   assign words_new = (cnt_q >> 1) + CNT_W'(cnt_q[0]);
   assign bytes_tot = {tot_q, 1'b0};
   assign dma_adv   = (dst_q == DST_PCM) ? DMA_W'(bytes_tot >> PCM_SHIFT)
                                         : DMA_W'(bytes_tot >> BIG_SHIFT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         rdy_q   <= 1'b0;
         done_q  <= 1'b0;
         kind_q  <= K_INVALID;
         dst_q   <= DST_NONE;
         bank_q  <= 1'b0;
         cnt_q   <= '0;
         words_q <= '0;
         tot_q   <= '0;
         addr_q  <= '0;
         dma_q   <= '0;
         off_q   <= '0;
         hdata_q <= '0;
      end else begin
         // control flags
         if (abort) begin
            busy_q <= 1'b0;
            rdy_q  <= 1'b0;
         end else if (fin) begin
            busy_q <= 1'b0;
            rdy_q  <= 1'b0;
            done_q <= 1'b1;
         end else if (trig_ok) begin
            busy_q <= 1'b1;
            done_q <= 1'b0;
            rdy_q  <= (kind_now == K_HOST_MAIN) || (kind_now == K_HOST_SUB);
         end

         // transfer setup latched on acceptance
         if (trig_ok) begin
            kind_q  <= kind_now;
            dst_q   <= dst_i;
            bank_q  <= bank_i;
            off_q   <= base_i;
            words_q <= words_new;
            tot_q   <= words_new;
         end else if (wr_fire) begin
            off_q   <= off_q + OFF_STEP;
            words_q <= words_q - CNT_W'(1);
         end

         // byte count
         if (abort || fin)
            cnt_q <= '0;
         else if (cnt_load_i)
            cnt_q <= cnt_val_i;
         else if (rd_ok || wr_fire)
            cnt_q <= cnt_q - CNT_STEP;

         // buffer data address
         if (addr_load_i)
            addr_q <= addr_val_i;
         else if (rd_ok || wr_fire)
            addr_q <= addr_q + ADDR_STEP;

         // destination word address
         if (dma_load_i)
            dma_q <= dma_val_i;
         else if (dma_last)
            dma_q <= dma_q + dma_adv;

         // host port data
         if (hrd_i)
            hdata_q <= rd_ok ? {buf_hi_i, buf_lo_i} : 16'h0000;
      end
   end

   assign hrd_data_o = hdata_q;
   assign dst_sel_o  = dst_q;
   assign dst_off_o  = off_q;
   assign dst_bank_o = bank_q;
   assign busy_o     = busy_q;
   assign host_rdy_o = rdy_q;
   assign done_o     = done_q;
   assign end_evt_o  = fin;
   assign cnt_o      = cnt_q;
   assign addr_o     = addr_q;
   assign dma_o      = dma_q;

   // R6
   done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_q && busy_q));

   // R3
   rdy_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_q |-> busy_q);

   // R6
   busy_fall_cnt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> (cnt_q == '0));

   // R8
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_we_o && !dst_rdy_i && !addr_load_i && xfer_en_i) |=>
         ($stable(off_q) && $stable(addr_q)));

   // R4
   rej_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hrd_i && !rd_ok) |=> (hdata_q == 16'h0000));

endmodule

// File: rtl/cdxfer_engine.sv
module cdxfer_engine
   import cdxfer_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 16,
   parameter int DMA_W  = 16,
   parameter int OFF_W  = 19,
   parameter bit HAS_1M = 1'b1
)
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_en_i,
   input  logic              end_irq_en_i,
   input  logic              irq5_en_i,
   input  logic              ack_i,
   input  logic              trig_i,
   input  logic [2:0]        mode_i,
   input  logic              cnt_load_i,
   input  logic [CNT_W-1:0]  cnt_val_i,
   input  logic              addr_load_i,
   input  logic [ADDR_W-1:0] addr_val_i,
   input  logic              dma_load_i,
   input  logic [DMA_W-1:0]  dma_val_i,
   input  logic              wm_1m_i,
   input  logic              wm_bank_i,
   input  logic              hrd_i,
   input  logic              hrd_sub_i,
   output logic [15:0]       hrd_data_o,
   output logic [ADDR_W-1:0] buf_addr_o,
   input  logic [7:0]        buf_hi_i,
   input  logic [7:0]        buf_lo_i,
   output logic              dst_we_o,
   output logic [1:0]        dst_sel_o,
   output logic [OFF_W-1:0]  dst_off_o,
   output logic              dst_bank_o,
   output logic [15:0]       dst_data_o,
   input  logic              dst_rdy_i,
   output logic              busy_o,
   output logic              host_rdy_o,
   output logic              done_o,
   output logic              end_pend_o,
   output logic              irq_o,
   output logic [CNT_W-1:0]  byte_cnt_o,
   output logic [ADDR_W-1:0] data_addr_o,
   output logic [DMA_W-1:0]  dma_addr_o
);

   localparam int PCM_SHIFT = 2;
   localparam int BIG_SHIFT = 3;

   generate
      if (CNT_W < 2) begin : g_cnt_bad
         $error("cdxfer_engine: CNT_W must be at least 2");
      end
      if (ADDR_W < 2) begin : g_addr_bad
         $error("cdxfer_engine: ADDR_W must be at least 2");
      end
   endgenerate

   dst_e             map_dst;
   logic [OFF_W-1:0] map_base;
   logic             map_bank;
   dst_e             seq_dst;
   logic             end_evt;

   cdxfer_dst_map #(
      .DMA_W      (DMA_W),
      .OFF_W      (OFF_W),
      .PCM_MASK_W (10),
      .W2M_MASK_W (15),
      .W1M_MASK_W (14),
      .PCM_SHIFT  (PCM_SHIFT),
      .BIG_SHIFT  (BIG_SHIFT),
      .HAS_1M     (HAS_1M)
   ) u_map (
      .mode_i    (mode_i),
      .dma_i     (dma_addr_o),
      .wm_1m_i   (wm_1m_i),
      .wm_bank_i (wm_bank_i),
      .dst_o     (map_dst),
      .base_o    (map_base),
      .bank_o    (map_bank)
   );

   cdxfer_seq #(
      .CNT_W     (CNT_W),
      .ADDR_W    (ADDR_W),
      .DMA_W     (DMA_W),
      .OFF_W     (OFF_W),
      .PCM_SHIFT (PCM_SHIFT),
      .BIG_SHIFT (BIG_SHIFT)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .xfer_en_i   (xfer_en_i),
      .trig_i      (trig_i),
      .mode_i      (mode_i),
      .cnt_load_i  (cnt_load_i),
      .cnt_val_i   (cnt_val_i),
      .addr_load_i (addr_load_i),
      .addr_val_i  (addr_val_i),
      .dma_load_i  (dma_load_i),
      .dma_val_i   (dma_val_i),
      .hrd_i       (hrd_i),
      .hrd_sub_i   (hrd_sub_i),
      .buf_hi_i    (buf_hi_i),
      .buf_lo_i    (buf_lo_i),
      .dst_rdy_i   (dst_rdy_i),
      .dst_i       (map_dst),
      .base_i      (map_base),
      .bank_i      (map_bank),
      .hrd_data_o  (hrd_data_o),
      .dst_we_o    (dst_we_o),
      .dst_sel_o   (seq_dst),
      .dst_off_o   (dst_off_o),
      .dst_bank_o  (dst_bank_o),
      .busy_o      (busy_o),
      .host_rdy_o  (host_rdy_o),
      .done_o      (done_o),
      .end_evt_o   (end_evt),
      .cnt_o       (byte_cnt_o),
      .addr_o      (data_addr_o),
      .dma_o       (dma_addr_o)
   );

   cdxfer_irq u_irq (
      .clk          (clk),
      .rst_n        (rst_n),
      .end_evt_i    (end_evt),
      .end_irq_en_i (end_irq_en_i),
      .irq5_en_i    (irq5_en_i),
      .ack_i        (ack_i),
      .end_pend_o   (end_pend_o),
      .irq_o        (irq_o)
   );

   assign dst_sel_o  = seq_dst;
   assign buf_addr_o = data_addr_o;
   assign dst_data_o = {buf_hi_i, buf_lo_i};

endmodule

// File: tb/tb_cdxfer_engine.sv
`timescale 1ns/1ps
module tb_cdxfer_engine;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xfer_en_i = 1'b1, end_irq_en_i = 1'b0, irq5_en_i = 1'b0, ack_i = 1'b0;
   logic        trig_i = 1'b0;
   logic [2:0]  mode_i = 3'd0;
   logic        cnt_load_i = 1'b0, addr_load_i = 1'b0, dma_load_i = 1'b0;
   logic [15:0] cnt_val_i = '0, addr_val_i = '0, dma_val_i = '0;
   logic        wm_1m_i = 1'b0, wm_bank_i = 1'b0;
   logic        hrd_i = 1'b0, hrd_sub_i = 1'b0;
   logic [15:0] hrd_data_o;
   logic [15:0] buf_addr_o;
   logic [7:0]  buf_hi_i, buf_lo_i;
   logic        dst_we_o;
   logic [1:0]  dst_sel_o;
   logic [18:0] dst_off_o;
   logic        dst_bank_o;
   logic [15:0] dst_data_o;
   logic        dst_rdy_i = 1'b1;
   logic        busy_o, host_rdy_o, done_o, end_pend_o, irq_o;
   logic [15:0] byte_cnt_o, data_addr_o, dma_addr_o;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   cdxfer_engine dut (.*);

   function automatic logic [7:0] bval(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h3C;
   endfunction

   function automatic logic [15:0] bword(input logic [15:0] a);
      return {bval(a), bval(a + 16'd1)};
   endfunction

   assign buf_hi_i = bval(buf_addr_o);
   assign buf_lo_i = bval(buf_addr_o + 16'd1);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   typedef struct packed {
      logic [2:0]  mode;
      logic [15:0] cnt;
      logic [15:0] dma;
      logic [15:0] data;
      logic        w1m;
      logic        wbank;
      logic [15:0] words;
      logic [18:0] base;
      logic        bank;
      logic [15:0] dma_end;
      logic [15:0] data_end;
   } vec_t;

   localparam int NVEC = 7;
   localparam vec_t VEC [0:NVEC-1] = '{
      {3'd4, 16'd7,  16'h0405, 16'h0010, 1'b0, 1'b0, 16'd4, 19'h00014, 1'b0, 16'h0407, 16'h0018},
      {3'd5, 16'd8,  16'h1234, 16'hFFFC, 1'b0, 1'b0, 16'd4, 19'h091A0, 1'b0, 16'h1235, 16'h0004},
      {3'd7, 16'd16, 16'h8003, 16'h0100, 1'b0, 1'b0, 16'd8, 19'h00018, 1'b0, 16'h8005, 16'h0110},
      {3'd7, 16'd5,  16'h4007, 16'h0020, 1'b1, 1'b1, 16'd3, 19'h00038, 1'b0, 16'h4007, 16'h0026},
      {3'd7, 16'd1,  16'h0002, 16'h0000, 1'b1, 1'b0, 16'd1, 19'h00010, 1'b1, 16'h0002, 16'h0002},
      {3'd4, 16'd0,  16'h0001, 16'h0030, 1'b0, 1'b0, 16'd0, 19'h00000, 1'b0, 16'h0001, 16'h0030},
      {3'd4, 16'd15, 16'h0003, 16'h0200, 1'b0, 1'b0, 16'd8, 19'h0000C, 1'b0, 16'h0007, 16'h0210}
   };

   task automatic load_all(input logic [15:0] c, input logic [15:0] a, input logic [15:0] d);
      @(negedge clk);
      cnt_val_i = c; addr_val_i = a; dma_val_i = d;
      cnt_load_i = 1'b1; addr_load_i = 1'b1; dma_load_i = 1'b1;
      @(negedge clk);
      cnt_load_i = 1'b0; addr_load_i = 1'b0; dma_load_i = 1'b0;
   endtask

   task automatic pulse_trig(input logic [2:0] m);
      mode_i = m;
      trig_i = 1'b1;
      @(negedge clk);
      trig_i = 1'b0;
   endtask

   task automatic host_read(input logic sub);
      @(negedge clk);
      hrd_i = 1'b1; hrd_sub_i = sub;
      @(negedge clk);
      hrd_i = 1'b0;
   endtask

   task automatic run_vec(input int i);
      vec_t v;
      int nw;
      int c;
      logic [1:0] esel;
      v = VEC[i];
      esel = (v.mode == 3'd4) ? 2'd1 : (v.mode == 3'd5) ? 2'd2 : 2'd3;
      wm_1m_i = v.w1m; wm_bank_i = v.wbank;
      load_all(v.cnt, v.data, v.dma);
      pulse_trig(v.mode);
      nw = 0;
      c = 0;
      while (busy_o && c < 400) begin
         dst_rdy_i = (c % 3 != 1);
         #1;
         if (dst_we_o && dst_rdy_i) begin
            // R9 offset, select and bank per word
            chk("R9 offset", 32'(dst_off_o), 32'(v.base + 19'(2 * nw)));
            chk("R9 select", 32'(dst_sel_o), 32'(esel));
            chk("R9 bank", 32'(dst_bank_o), 32'(v.bank));
            // R8 data from consecutive buffer bytes
            chk("R8 data", 32'(dst_data_o), 32'(bword(v.data + 16'(2 * nw))));
            nw++;
         end
         c++;
         @(negedge clk);
      end
      dst_rdy_i = 1'b1;
      chk("R8 word count", 32'(nw), 32'(v.words));
      chk("R8 data address end", 32'(data_addr_o), 32'(v.data_end));
      chk("R10 dma address advance", 32'(dma_addr_o), 32'(v.dma_end));
      chk("R6 count zero at end", 32'(byte_cnt_o), 32'd0);
      chk("R6 done flag", 32'(done_o), 32'd1);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 busy", 32'(busy_o), 0);
      chk("R1 done", 32'(done_o), 0);
      chk("R1 ready", 32'(host_rdy_o), 0);
      chk("R1 pend/irq", {30'd0, end_pend_o, irq_o}, 0);
      chk("R1 counters", {byte_cnt_o, data_addr_o}, 0);
      chk("R1 hdata/we", {15'd0, dst_we_o, hrd_data_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // DMA vector table: R8 R9 R10
      for (int i = 0; i < NVEC; i++) run_vec(i);
      wm_1m_i = 1'b0; wm_bank_i = 1'b0;

      // R2 trigger ignored while transfer disabled
      load_all(16'd4, 16'h0040, 16'h0000);
      xfer_en_i = 1'b0;
      pulse_trig(3'd2);
      chk("R2 trigger ignored when disabled", 32'(busy_o), 0);
      xfer_en_i = 1'b1;
      @(negedge clk);

      // host mode 2, main CPU, end interrupt on
      end_irq_en_i = 1'b1; irq5_en_i = 1'b1;
      load_all(16'd5, 16'h0040, 16'h0000);
      pulse_trig(3'd2);
      chk("R2 busy after trigger", 32'(busy_o), 1);
      chk("R2 done cleared", 32'(done_o), 0);
      chk("R3 host ready", 32'(host_rdy_o), 1);
      host_read(1'b1);
      chk("R4 wrong reader data", 32'(hrd_data_o), 0);
      chk("R4 wrong reader count", 32'(byte_cnt_o), 5);
      chk("R4 wrong reader addr", 32'(data_addr_o), 32'h40);
      host_read(1'b0);
      chk("R5 read data", 32'(hrd_data_o), 32'(bword(16'h0040)));
      chk("R5 count", 32'(byte_cnt_o), 3);
      chk("R5 addr", 32'(data_addr_o), 32'h42);
      host_read(1'b0);
      chk("R5 count second", 32'(byte_cnt_o), 1);
      host_read(1'b0);
      chk("R5 last data", 32'(hrd_data_o), 32'(bword(16'h0044)));
      chk("R6 count zero", 32'(byte_cnt_o), 0);
      chk("R6 busy clear", 32'(busy_o), 0);
      chk("R6 ready clear", 32'(host_rdy_o), 0);
      chk("R6 done set", 32'(done_o), 1);
      chk("R7 pending set", 32'(end_pend_o), 1);
      chk("R7 irq pulse", 32'(irq_o), 1);
      @(negedge clk);
      chk("R7 irq one cycle", 32'(irq_o), 0);
      chk("R7 pending held", 32'(end_pend_o), 1);
      host_read(1'b0);
      chk("R4 idle read data", 32'(hrd_data_o), 0);
      chk("R4 idle read addr", 32'(data_addr_o), 32'h46);
      ack_i = 1'b1;
      @(negedge clk);
      ack_i = 1'b0;
      chk("R7 ack clears pending", 32'(end_pend_o), 0);

      // R12 trigger while busy ignored, then R11 abort
      irq5_en_i = 1'b0;
      load_all(16'd10, 16'h0080, 16'h0000);
      pulse_trig(3'd3);
      host_read(1'b1);
      chk("R5 sub read count", 32'(byte_cnt_o), 8);
      pulse_trig(3'd2);
      host_read(1'b1);
      chk("R12 mode kept data", 32'(hrd_data_o), 32'(bword(16'h0082)));
      chk("R12 mode kept count", 32'(byte_cnt_o), 6);
      host_read(1'b0);
      chk("R12 main reader still rejected", 32'(hrd_data_o), 0);
      @(negedge clk);
      xfer_en_i = 1'b0;
      @(negedge clk);
      chk("R11 abort busy", 32'(busy_o), 0);
      chk("R11 abort count", 32'(byte_cnt_o), 0);
      chk("R11 abort no done", 32'(done_o), 0);
      chk("R11 abort no pending", 32'(end_pend_o), 0);
      xfer_en_i = 1'b1;

      // R7 end with level-5 enable off
      load_all(16'd2, 16'h0010, 16'h0000);
      pulse_trig(3'd3);
      host_read(1'b1);
      chk("R7 pending without irq", 32'(end_pend_o), 1);
      chk("R7 no irq when disabled", 32'(irq_o), 0);
      ack_i = 1'b1;
      @(negedge clk);
      ack_i = 1'b0;

      // R3 invalid mode: busy, no ready, no writes
      load_all(16'd8, 16'h0000, 16'h0000);
      pulse_trig(3'd6);
      chk("R3 invalid busy", 32'(busy_o), 1);
      chk("R3 invalid no ready", 32'(host_rdy_o), 0);
      for (int k = 0; k < 4; k++) begin
         chk("R3 invalid no write", 32'(dst_we_o), 0);
         @(negedge clk);
      end
      xfer_en_i = 1'b0;
      @(negedge clk);
      chk("R11 invalid abort", 32'(busy_o), 0);
      xfer_en_i = 1'b1;
      @(negedge clk);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule